// File: doc/BRIEF.md
# PCI Function Power State Controller

This block keeps the power state of one PCI network function and decides, from that state, whether the function may act as a bus target and whether a wake event may pull the active-low power-management-event line. Software moves the function between the full-power state and the reduced-power states through a 2-bit power-state field. Writes to any base address register finish initialization. A main-power-lost input forces the unpowered deep state.

The full-power state is split in two. After power-on reset the function is reachable but not yet initialized. The first base-address write moves it to the active substate. Link-status-change wake is honoured only in the active substate. Wake-packet matches may wake the host from every state, but the unpowered deep state needs auxiliary power. A wake event latches a status bit only while wake signalling is enabled. The latched status holds the event line low until software clears it.

Top module: `pci_pwr_ctl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `pwr_state` reads 0 (D0 uninitialized), `tgt_permit` is 1, `pme_n` is 1, and both wake-enable and wake-status are clear.
- R2: A write to any bit of `bar_wr` while in D0 uninitialized (code 0), with no `ps_wr` and no `main_pwr_lost`, gives D0 active (code 1) on the next cycle.
- R3: `tgt_permit` is 1 exactly when `pwr_state` is 0 or 1, and 0 in every other state.
- R4: `pwr_state` codes are 0=D0 uninitialized, 1=D0 active, 2=D1, 3=D2, 4=D3hot, 5=D3cold. A `ps_wr` with `ps_val` 2'b01, 2'b10 or 2'b11 gives D1, D2 or D3hot on the next cycle. A `ps_wr` with 2'b00 from D1 or D2 gives code 1 if a base address was written since the last reset or D3hot exit, and code 0 otherwise.
- R5: A `ps_wr` with 2'b00 from D3hot gives code 0 and forgets earlier base-address writes, including any made while in D3hot.
- R6: `main_pwr_lost` gives D3cold (code 5) on the next cycle from any state. In D3cold, writes to the power-state field, the base address registers, wake-enable and wake-status are ignored. Only `rst_n` leaves D3cold.
- R7: `link_chg` sets wake-status only in D0 active.
- R8: `wake_pkt` sets wake-status in every state except D3cold. In D3cold it sets wake-status only while `aux_pwr` is 1.
- R9: A wake event that arrives while wake-enable is clear is dropped: wake-status stays clear, so a later enable does not drive `pme_n` low.
- R10: `pme_n` is 0 while wake-status and wake-enable are both set. Wake-status holds until a `pme_sts_clr` write. If a clear and a qualifying event arrive in the same cycle, the status stays set.
- R11: In D3cold, `pme_n` is 1 whenever `aux_pwr` is 0, whatever the wake-status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| main_pwr_lost | input | 1 | Main power has gone; enter D3cold |
| aux_pwr | input | 1 | Auxiliary power present |
| ps_wr | input | 1 | Write strobe for the power-state field |
| ps_val | input | 2 | Power-state field value (00 D0, 01 D1, 10 D2, 11 D3hot) |
| bar_wr | input | NUM_BARS | One strobe per base address register |
| pme_en_wr | input | 1 | Write strobe for the wake-enable bit |
| pme_en_val | input | 1 | Wake-enable value written |
| pme_sts_clr | input | 1 | Write-one-to-clear of the wake-status bit |
| link_chg | input | 1 | Link-status-change event |
| wake_pkt | input | 1 | Wake-packet match event |
| pwr_state | output | 3 | Current power state code |
| tgt_permit | output | 1 | Non-configuration target transactions allowed |
| pme_n | output | 1 | Active-low power-management event |

## Verification
Every cycle, the assertions check the following. Reset lands in D0 uninitialized. D3cold is entered on power loss and is never left without reset. A base-address write activates D0 uninitialized. D3hot exits through the uninitialized substate. Latched wake-status persists without a clear. A disabled enable, or a missing auxiliary supply in D3cold, keeps `pme_n` high. Link events outside D0 active never create a status.

Only the bench scenarios can show the effects that build up over sequences of cycles. A dropped event leaves no trace once wake signalling is enabled. The base-address flag survives D1 and D2 but not D3hot. A clear loses to a simultaneous event. Status latched with auxiliary power returns on `pme_n` when auxiliary power comes back.

// File: rtl/pci_pwr_pkg.sv
package pci_pwr_pkg;

   typedef enum logic [2:0] {
      PS_D0U   = 3'd0,
      PS_D0A   = 3'd1,
      PS_D1    = 3'd2,
      PS_D2    = 3'd3,
      PS_D3HOT = 3'd4,
      PS_D3COLD= 3'd5
   } pwr_state_e;

   localparam int unsigned PS_FIELD_W = 2;

   localparam logic [PS_FIELD_W-1:0] FLD_D0   = 2'b00;
   localparam logic [PS_FIELD_W-1:0] FLD_D1   = 2'b01;
   localparam logic [PS_FIELD_W-1:0] FLD_D2   = 2'b10;
   localparam logic [PS_FIELD_W-1:0] FLD_D3   = 2'b11;

   function automatic logic in_full_power(input pwr_state_e s);
      return (s == PS_D0U) || (s == PS_D0A);
   endfunction

endpackage

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
   import pci_pwr_pkg::*;
#(
   parameter int unsigned NUM_BARS = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  main_lost,
   input  logic                  ps_wr,
   input  logic [PS_FIELD_W-1:0] ps_val,
   input  logic [NUM_BARS-1:0]   bar_wr,
   output pwr_state_e            state_o
);

   generate
      if (NUM_BARS < 1 || NUM_BARS > 6) begin : g_bad_bars
         $error("pwr_state_fsm: NUM_BARS must be 1..6");
      end
   endgenerate

   pwr_state_e state_q, state_d;
   logic       bar_seen_q, bar_seen_d;
   logic       any_bar;

   assign any_bar = |bar_wr;

   always_comb begin
      state_d    = state_q;
      bar_seen_d = bar_seen_q;
      if (main_lost) begin
         state_d = PS_D3COLD;
      end else if (state_q != PS_D3COLD) begin
         if (any_bar) bar_seen_d = 1'b1;
         if (ps_wr) begin
            unique case (ps_val)
               FLD_D0: begin
                  if (state_q == PS_D3HOT) begin
                     bar_seen_d = 1'b0;
                     state_d    = PS_D0U;
                  end else begin
                     state_d = bar_seen_d ? PS_D0A : PS_D0U;
                  end
               end
               FLD_D1:  state_d = PS_D1;
               FLD_D2:  state_d = PS_D2;
               default: state_d = PS_D3HOT;
            endcase
         end else if (state_q == PS_D0U && any_bar) begin
            state_d = PS_D0A;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PS_D0U;
         bar_seen_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         bar_seen_q <= bar_seen_d;
      end
   end

   assign state_o = state_q;

   AST_RESET_D0U: assert property (@(posedge clk) !rst_n |=> state_q == PS_D0U); // R1
   AST_BAR_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_D0U && any_bar && !ps_wr && !main_lost) |=> state_q == PS_D0A); // R2
   AST_D3HOT_EXIT_D0U: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_D3HOT && ps_wr && ps_val == FLD_D0 && !main_lost) |=> state_q == PS_D0U); // R5
   AST_LOSS_TO_COLD: assert property (@(posedge clk) disable iff (!rst_n)
      main_lost |=> state_q == PS_D3COLD); // R6
   AST_COLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == PS_D3COLD |=> state_q == PS_D3COLD); // R6

endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
   import pci_pwr_pkg::*;
#(
   parameter bit PKT_WAKE_IN_D0A = 1'b1
) (
   input  pwr_state_e state,
   input  logic       aux_pwr,
   input  logic       link_chg,
   input  logic       wake_pkt,
   output logic       wake_hit
);

   logic link_ok;
   logic pkt_state_ok;
   logic pkt_ok;

   assign link_ok = link_chg && (state == PS_D0A);

   generate
      if (PKT_WAKE_IN_D0A) begin : g_pkt_all
         assign pkt_state_ok = 1'b1;
      end else begin : g_pkt_no_d0a
         assign pkt_state_ok = (state != PS_D0A);
      end
   endgenerate

   assign pkt_ok   = wake_pkt && pkt_state_ok && ((state != PS_D3COLD) || aux_pwr);
   assign wake_hit = link_ok || pkt_ok;

   always_comb begin
      AST_COLD_NEEDS_AUX: assert (!(state == PS_D3COLD && !aux_pwr && wake_hit)); // R8
   end

endmodule

// File: rtl/pme_status_reg.sv
module pme_status_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_live,
   input  logic en_wr,
   input  logic en_val,
   input  logic sts_clr,
   input  logic wake_hit,
   input  logic out_live,
   output logic sts_o,
   output logic pme_n
);

   logic en_q, sts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sts_q <= 1'b0;
      end else begin
         if (cfg_live && en_wr) en_q <= en_val;
         if (en_q && wake_hit)
            sts_q <= 1'b1;
         else if (cfg_live && sts_clr)
            sts_q <= 1'b0;
      end
   end

   assign sts_o = sts_q;
   assign pme_n = ~(sts_q & en_q & out_live);

   AST_NO_PME_WO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> pme_n); // R9
   AST_DROP_WO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !sts_q) |=> !sts_q); // R9
   AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !(cfg_live && sts_clr)) |=> sts_q); // R10

endmodule

// File: rtl/pci_pwr_ctl.sv
module pci_pwr_ctl
   import pci_pwr_pkg::*;
#(
   parameter int unsigned NUM_BARS        = 3,
   parameter bit          PKT_WAKE_IN_D0A = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  main_pwr_lost,
   input  logic                  aux_pwr,
   input  logic                  ps_wr,
   input  logic [1:0]            ps_val,
   input  logic [NUM_BARS-1:0]   bar_wr,
   input  logic                  pme_en_wr,
   input  logic                  pme_en_val,
   input  logic                  pme_sts_clr,
   input  logic                  link_chg,
   input  logic                  wake_pkt,
   output logic [2:0]            pwr_state,
   output logic                  tgt_permit,
   output logic                  pme_n
);

   pwr_state_e state;
   logic       wake_hit;
   logic       sts;
   logic       cfg_live;
   logic       out_live;

   pwr_state_fsm #(.NUM_BARS(NUM_BARS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .main_lost (main_pwr_lost),
      .ps_wr     (ps_wr),
      .ps_val    (ps_val),
      .bar_wr    (bar_wr),
      .state_o   (state)
   );

   wake_qualifier #(.PKT_WAKE_IN_D0A(PKT_WAKE_IN_D0A)) u_wake (
      .state    (state),
      .aux_pwr  (aux_pwr),
      .link_chg (link_chg),
      .wake_pkt (wake_pkt),
      .wake_hit (wake_hit)
   );

   assign cfg_live = (state != PS_D3COLD);
   assign out_live = cfg_live || aux_pwr;

   pme_status_reg u_pme (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_live (cfg_live),
      .en_wr    (pme_en_wr),
      .en_val   (pme_en_val),
      .sts_clr  (pme_sts_clr),
      .wake_hit (wake_hit),
      .out_live (out_live),
      .sts_o    (sts),
      .pme_n    (pme_n)
   );

   assign pwr_state  = state;
   assign tgt_permit = in_full_power(state);

   AST_COLD_NO_AUX: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd5 && !aux_pwr) |-> pme_n); // R11
   AST_LINK_ONLY_D0A: assert property (@(posedge clk) disable iff (!rst_n)
      (link_chg && !wake_pkt && pwr_state != 3'd1 && !sts) |=> !sts); // R7

endmodule

// File: tb/tb_pci_pwr_ctl.sv
module tb_pci_pwr_ctl;

   localparam int NB = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          main_pwr_lost = 1'b0, aux_pwr = 1'b0;
   logic          ps_wr = 1'b0;
   logic [1:0]    ps_val = 2'b00;
   logic [NB-1:0] bar_wr = '0;
   logic          pme_en_wr = 1'b0, pme_en_val = 1'b0, pme_sts_clr = 1'b0;
   logic          link_chg = 1'b0, wake_pkt = 1'b0;
   logic [2:0]    pwr_state;
   logic          tgt_permit, pme_n;

   int checks = 0;
   int errors = 0;

   pci_pwr_ctl #(.NUM_BARS(NB)) dut (
      .clk(clk), .rst_n(rst_n), .main_pwr_lost(main_pwr_lost), .aux_pwr(aux_pwr),
      .ps_wr(ps_wr), .ps_val(ps_val), .bar_wr(bar_wr), .pme_en_wr(pme_en_wr),
      .pme_en_val(pme_en_val), .pme_sts_clr(pme_sts_clr), .link_chg(link_chg),
      .wake_pkt(wake_pkt), .pwr_state(pwr_state), .tgt_permit(tgt_permit), .pme_n(pme_n)
   );

   always #10 clk = ~clk;

   typedef struct packed {
      logic       ps_wr;
      logic [1:0] ps_val;
      logic       bar;
      logic       en_wr;
      logic       en_val;
      logic       clr;
      logic       aux;
      logic       lost;
      logic       link;
      logic       pkt;
      logic [2:0] st;
      logic       permit;
      logic       pmen;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 35;
   // fields: ps_wr ps_val bar en_wr en_val clr aux lost link pkt | state permit pme_n req
   localparam vec_t VEC [NV] = '{
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b1,1'b1,4'd1 },  // R1 idle
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd0,1'b1,1'b1,4'd9 },  // R9 pkt, enable clear
      '{1'b0,2'b00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b1,1'b1,4'd9 },  // R9 enable, no stored status
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 3'd0,1'b1,1'b1,4'd7 },  // R7 link in D0u
      '{1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b1,1'b1,4'd2 },  // R2 BAR -> D0a
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 3'd1,1'b1,1'b0,4'd7 },  // R7 link in D0a
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b1,1'b1,4'd10},  // R10 clear
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b1,1'b1,4'd10},  // R10 stays clear
      '{1'b1,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b0,1'b1,4'd3 },  // R3 D1
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd2,1'b0,1'b0,4'd8 },  // R8 pkt in D1
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b0,1'b0,4'd10},  // R10 hold
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 3'd2,1'b0,1'b0,4'd10},  // R10 event beats clear
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b0,1'b1,4'd10},  // R10 clear
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 3'd2,1'b0,1'b1,4'd7 },  // R7 link in D1
      '{1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b1,1'b1,4'd4 },  // R4 D1->D0a
      '{1'b1,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b1,4'd4 },  // R4 D2
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd3,1'b0,1'b0,4'd8 },  // R8 pkt in D2
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b1,4'd10},  // R10 clear
      '{1'b1,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b1,4'd3 },  // R3 D3hot
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd4,1'b0,1'b0,4'd8 },  // R8 pkt in D3hot
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b1,4'd10},  // R10 clear
      '{1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b1,4'd5 },  // R5 BAR in D3hot
      '{1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b1,1'b1,4'd5 },  // R5 D3hot->D0u
      '{1'b1,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b0,1'b1,4'd4 },  // R4 D1
      '{1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b1,1'b1,4'd5 },  // R5 flag forgotten
      '{1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b1,1'b1,4'd2 },  // R2 BAR again
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd5,1'b0,1'b1,4'd6 },  // R6 power lost
      '{1'b1,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd5,1'b0,1'b1,4'd6 },  // R6 writes ignored
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 3'd5,1'b0,1'b1,4'd11},  // R11 pkt, no aux
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd5,1'b0,1'b1,4'd8 },  // R8 not stored
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 3'd5,1'b0,1'b0,4'd8 },  // R8 pkt with aux
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd5,1'b0,1'b1,4'd11},  // R11 aux gone
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd5,1'b0,1'b0,4'd11},  // R11 aux back
      '{1'b0,2'b00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'd5,1'b0,1'b0,4'd6 },  // R6 clear ignored
      '{1'b0,2'b00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd5,1'b0,1'b0,4'd6 }   // R6 enable write ignored
   };

   task automatic check(input int req, input logic [2:0] st, input logic pm, input logic pn);
      checks++;
      if (pwr_state !== st || tgt_permit !== pm || pme_n !== pn) begin
         errors++;
         $display("FAIL R%0d: state=%0d permit=%0b pme_n=%0b expected state=%0d permit=%0b pme_n=%0b",
                  req, pwr_state, tgt_permit, pme_n, st, pm, pn);
      end
   endtask

   task automatic idle_inputs();
      ps_wr = 1'b0; ps_val = 2'b00; bar_wr = '0; pme_en_wr = 1'b0; pme_en_val = 1'b0;
      pme_sts_clr = 1'b0; link_chg = 1'b0; wake_pkt = 1'b0; main_pwr_lost = 1'b0;
   endtask

   // drive at negedge, let one posedge pass, sample 2 ns after it
   task automatic cycle();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      #1;
      check(1, 3'd0, 1'b1, 1'b1);   // R1 during reset
      @(negedge clk);
      rst_n = 1'b1;
      cycle();
      check(1, 3'd0, 1'b1, 1'b1);   // R1 after release
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cycle();
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ps_wr = VEC[i].ps_wr; ps_val = VEC[i].ps_val;
         bar_wr = {{(NB-1){1'b0}}, VEC[i].bar};
         pme_en_wr = VEC[i].en_wr; pme_en_val = VEC[i].en_val;
         pme_sts_clr = VEC[i].clr; aux_pwr = VEC[i].aux;
         main_pwr_lost = VEC[i].lost; link_chg = VEC[i].link; wake_pkt = VEC[i].pkt;
         cycle();
         check(VEC[i].req, VEC[i].st, VEC[i].permit, VEC[i].pmen);
      end

      // R1: reset leaves D3cold and clears enable and status
      do_reset();
      aux_pwr = 1'b0;

      // R2: highest BAR strobe also activates
      @(negedge clk); idle_inputs(); bar_wr = 3'b100;
      cycle(); check(2, 3'd1, 1'b1, 1'b1);

      // R9/R10: enable cleared while status set hides PME, re-enable shows it
      @(negedge clk); idle_inputs(); pme_en_wr = 1'b1; pme_en_val = 1'b1;
      cycle(); check(9, 3'd1, 1'b1, 1'b1);
      @(negedge clk); idle_inputs(); link_chg = 1'b1;
      cycle(); check(7, 3'd1, 1'b1, 1'b0);
      @(negedge clk); idle_inputs(); pme_en_wr = 1'b1; pme_en_val = 1'b0;
      cycle(); check(9, 3'd1, 1'b1, 1'b1);
      @(negedge clk); idle_inputs(); pme_en_wr = 1'b1; pme_en_val = 1'b1;
      cycle(); check(10, 3'd1, 1'b1, 1'b0);

      // R4: D2 back to D0 keeps the active substate
      @(negedge clk); idle_inputs(); pme_sts_clr = 1'b1;
      cycle(); check(10, 3'd1, 1'b1, 1'b1);
      @(negedge clk); idle_inputs(); ps_wr = 1'b1; ps_val = 2'b10;
      cycle(); check(4, 3'd3, 1'b0, 1'b1);
      @(negedge clk); idle_inputs(); ps_wr = 1'b1; ps_val = 2'b00;
      cycle(); check(4, 3'd1, 1'b1, 1'b1);

      // R6: power loss from D2, then only reset recovers
      @(negedge clk); idle_inputs(); ps_wr = 1'b1; ps_val = 2'b10;
      cycle(); check(4, 3'd3, 1'b0, 1'b1);
      @(negedge clk); idle_inputs(); main_pwr_lost = 1'b1;
      cycle(); check(6, 3'd5, 1'b0, 1'b1);
      @(negedge clk); idle_inputs();
      cycle(); check(6, 3'd5, 1'b0, 1'b1);
      do_reset();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule